// File: doc/BRIEF.md
# Memory Test Traffic Sequencer

This block is a free-running memory exerciser that sits in front of a memory controller as a pipelined Wishbone master. Once the memory reports ready, it generates an unending stream of requests in three access patterns. It writes data that is a fixed function of the address and compares every word it reads back against that function. Matched and mismatched reads are counted. A single-cycle pulse from an already debounced button corrupts one written word on purpose, which makes the checking path visible from outside.

The three patterns run in a fixed loop. The first is a linear pass: every word is written in ascending order, then every word is read back in the same order. The second is a scatter pass, which uses the same write-then-read split but rotates the index halves so that consecutive accesses land in different rows. The third is a ping-pong pass, which writes one word and reads it back at once before moving on. The request side follows Wishbone pipelined back-pressure rules. A request is presented on `wb_stb` and transfers on the first edge where `wb_stall` is low; until then it is held unchanged. Responses come back in order on `wb_ack` and are never refused. Read data is not stored anywhere: a small queue keeps only the address and direction of each request in flight, and the expected word is regenerated from the address when the ack arrives.

Top module: `mem_traffic_exerciser`

## Requirements
- R1: Out of reset all three counters are zero, `mode` is 0 and `wb_stb` and `wb_cyc` are low. No request is issued until `mem_ready` has been sampled high at a clock edge.
- R2: `mode` shows the running pattern with 0 = linear, 1 = scatter and 2 = ping-pong. It steps 0, 1, 2, 0, ... and never runs in any other order.
- R3: In linear mode the sequencer writes word addresses 0 to 2**WORD_AW-1 in ascending order, then reads the same addresses in the same order.
- R4: In scatter mode, with index c running from 0 to 2**WORD_AW-1 and H = WORD_AW/2 (rounded down), the address is {c[H-1:0], c[WORD_AW-1:H]}. All addresses are written in that order, then read back in the same order.
- R5: In ping-pong mode, for each ascending address i, a write to i is followed directly by a read of i.
- R6: Let k = address XOR SEED (low WORD_AW bits). Bit b of a clean write word equals bit (b mod WORD_AW) of k, inverted when (b div WORD_AW) is odd. `wb_sel` is all ones, and `wb_adr` is the word address zero-extended.
- R7: While `wb_stb` is high and `wb_stall` is high, the next cycle keeps `wb_stb` high with `wb_adr`, `wb_we` and (for writes) `wb_dat_w` unchanged.
- R8: No more than FIFO_DEPTH requests are outstanding. Acks are matched to requests in issue order. Each read ack increments `match_cnt` if the data equals the R6 word for its address, and `mismatch_cnt` otherwise; the new value is visible after the ack edge.
- R9: A `fault_inject` pulse makes exactly one later write go out with bit 0 inverted. `fault_cnt` increments at the edge where that write is accepted. The checker still expects the clean word, so the read-back adds one to `mismatch_cnt`. A pulse arriving while a write waits on stall takes effect on a write accepted after that one.
- R10: Each counter stops at its all-ones value instead of wrapping.
- R11: `wb_cyc` is high exactly when `wb_stb` is high or at least one request is awaiting its ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Memory controller has finished initialisation |
| fault_inject | input | 1 | Single-cycle request to corrupt one write |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Request valid |
| wb_we | output | 1 | Request is a write |
| wb_adr | output | BUS_AW | Word address |
| wb_dat_w | output | DATA_W | Write data |
| wb_sel | output | DATA_W/8 | Byte enables, all set |
| wb_stall | input | 1 | Request not accepted this cycle |
| wb_ack | input | 1 | In-order response strobe |
| wb_dat_r | input | DATA_W | Read data, valid with a read ack |
| match_cnt | output | COUNT_W | Reads equal to the expected word |
| mismatch_cnt | output | COUNT_W | Reads differing from the expected word |
| fault_cnt | output | COUNT_W | Corrupted writes issued |
| mode | output | 2 | Running pattern: 0 linear, 1 scatter, 2 ping-pong |

## Verification
The hardest situations to reach from the ports are a fault pulse that lands while a write is stalled, and a full in-flight queue. Both depend on how the bus slave behaves and not on the sequencer. The bench's memory model therefore runs periodic stall bursts and, separately, long windows where it holds back acks, so the queue fills to its limit and the sequencer has to pause. Fault pulses are placed at irregular cycles so that some of them meet a stalled write. The run is long enough for the 8-bit match counter to reach saturation while the mismatch and fault counts stay small and must end equal.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    MODE_LINEAR   = 2'd0,
    MODE_SCATTER  = 2'd1,
    MODE_PINGPONG = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_LIN_WR,
    ST_LIN_RD,
    ST_SCT_WR,
    ST_SCT_RD,
    ST_PP
  } state_e;

endpackage

// File: rtl/mtx_pattern.sv
module mtx_pattern #(
  parameter int          AW   = 10,
  parameter int          DW   = 64,
  parameter logic [31:0] SEED = 32'h5A3C_96E1
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  logic [AW-1:0] key;
  assign key = addr ^ AW'(SEED);

  // Replicate the keyed address; odd copies are inverted for more toggling.
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign word[b] = key[b % AW] ^ (((b / AW) % 2) == 1);
  end
endmodule

// File: rtl/mtx_sat_counter.sv
module mtx_sat_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  a_r10_stick_at_top: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == TOP));
  a_r10_step_of_one: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/mtx_inflight_fifo.sv
module mtx_inflight_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  assign dout  = slots[rp];
  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r8_ack_has_request: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/mtx_addr_seq.sv
module mtx_addr_seq
  import mtx_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_ready,
  input  logic          slot_free,
  input  logic          accept,
  output logic          req_valid,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output mode_e         mode
);
  localparam int HALF = AW / 2;
  localparam logic [AW-1:0] IDX_LAST = '1;

  state_e        st_q;
  logic [AW-1:0] idx_q;
  logic          pp_rd_q;
  logic [AW-1:0] idx_swz;

  if (HALF > 0) begin : g_swap
    assign idx_swz = {idx_q[HALF-1:0], idx_q[AW-1:HALF]};
  end else begin : g_noswap
    assign idx_swz = idx_q;
  end

  function automatic state_e next_phase(input state_e s);
    case (s)
      ST_LIN_WR: return ST_LIN_RD;
      ST_LIN_RD: return ST_SCT_WR;
      ST_SCT_WR: return ST_SCT_RD;
      ST_SCT_RD: return ST_PP;
      default:   return ST_LIN_WR;
    endcase
  endfunction

  always_comb begin
    req_valid = (st_q != ST_WAIT) && slot_free;
    req_we    = 1'b0;
    req_addr  = idx_q;
    mode      = MODE_LINEAR;
    case (st_q)
      ST_LIN_WR: req_we = 1'b1;
      ST_SCT_WR: begin
        req_we   = 1'b1;
        req_addr = idx_swz;
        mode     = MODE_SCATTER;
      end
      ST_SCT_RD: begin
        req_addr = idx_swz;
        mode     = MODE_SCATTER;
      end
      ST_PP: begin
        req_we = !pp_rd_q;
        mode   = MODE_PINGPONG;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_WAIT;
      idx_q   <= '0;
      pp_rd_q <= 1'b0;
    end else if (st_q == ST_WAIT) begin
      if (mem_ready) st_q <= ST_LIN_WR;
    end else if (accept) begin
      if (st_q == ST_PP && !pp_rd_q) begin
        pp_rd_q <= 1'b1;
      end else begin
        pp_rd_q <= 1'b0;
        idx_q   <= idx_q + 1'b1;
        if (idx_q == IDX_LAST) st_q <= next_phase(st_q);
      end
    end
  end

  a_r2_mode_order: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |->
      (($past(mode) == MODE_LINEAR   && mode == MODE_SCATTER)  ||
       ($past(mode) == MODE_SCATTER  && mode == MODE_PINGPONG) ||
       ($past(mode) == MODE_PINGPONG && mode == MODE_LINEAR)));
endmodule

// File: rtl/mem_traffic_exerciser.sv
module mem_traffic_exerciser
  import mtx_pkg::*;
#(
  parameter int          BUS_AW     = 32,
  parameter int          WORD_AW    = 10,
  parameter int          DATA_W     = 64,
  parameter int          FIFO_DEPTH = 4,
  parameter int          COUNT_W    = 64,
  parameter logic [31:0] SEED       = 32'h5A3C_96E1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mem_ready,
  input  logic                  fault_inject,
  output logic                  wb_cyc,
  output logic                  wb_stb,
  output logic                  wb_we,
  output logic [BUS_AW-1:0]     wb_adr,
  output logic [DATA_W-1:0]     wb_dat_w,
  output logic [DATA_W/8-1:0]   wb_sel,
  input  logic                  wb_stall,
  input  logic                  wb_ack,
  input  logic [DATA_W-1:0]     wb_dat_r,
  output logic [COUNT_W-1:0]    match_cnt,
  output logic [COUNT_W-1:0]    mismatch_cnt,
  output logic [COUNT_W-1:0]    fault_cnt,
  output logic [1:0]            mode
);
  localparam int FLW = WORD_AW + 1;
  localparam logic [DATA_W-1:0] FLIP = DATA_W'(1);

  logic               req_valid, req_we, accept, hold;
  logic [WORD_AW-1:0] req_addr;
  mode_e              seq_mode;
  logic               q_empty, q_full;
  logic [FLW-1:0]     q_head;
  logic               head_we;
  logic [WORD_AW-1:0] head_addr;
  logic [DATA_W-1:0]  wr_word, rd_expect;
  logic               flt_armed, flt_wait;
  logic [2:0]         cnt_inc;
  logic [COUNT_W-1:0] cnt_val [3];

  mtx_addr_seq #(.AW(WORD_AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mem_ready (mem_ready),
    .slot_free (!q_full),
    .accept    (accept),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .mode      (seq_mode)
  );

  assign wb_stb = req_valid;
  assign accept = wb_stb && !wb_stall;
  assign hold   = wb_stb && wb_stall;

  mtx_inflight_fifo #(.W(FLW), .DEPTH(FIFO_DEPTH)) u_flight (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .din   ({req_we, req_addr}),
    .pop   (wb_ack),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );
  assign head_we   = q_head[FLW-1];
  assign head_addr = q_head[WORD_AW-1:0];

  mtx_pattern #(.AW(WORD_AW), .DW(DATA_W), .SEED(SEED)) u_wr_pat (
    .addr (req_addr),
    .word (wr_word)
  );
  mtx_pattern #(.AW(WORD_AW), .DW(DATA_W), .SEED(SEED)) u_rd_pat (
    .addr (head_addr),
    .word (rd_expect)
  );

  // A pulse seen during a stalled request is parked so the held word stays stable.
  always_ff @(posedge clk) begin
    if (rst) begin
      flt_armed <= 1'b0;
      flt_wait  <= 1'b0;
    end else if (hold) begin
      if (fault_inject) flt_wait <= 1'b1;
    end else begin
      flt_armed <= (flt_armed && !(accept && req_we)) || fault_inject || flt_wait;
      flt_wait  <= 1'b0;
    end
  end

  assign wb_we    = req_we;
  assign wb_adr   = BUS_AW'(req_addr);
  assign wb_dat_w = (req_we && flt_armed) ? (wr_word ^ FLIP) : wr_word;
  assign wb_sel   = '1;
  assign wb_cyc   = wb_stb || !q_empty;
  assign mode     = seq_mode;

  assign cnt_inc[0] = wb_ack && !head_we && (wb_dat_r == rd_expect);
  assign cnt_inc[1] = wb_ack && !head_we && (wb_dat_r != rd_expect);
  assign cnt_inc[2] = accept && req_we && flt_armed;

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    mtx_sat_counter #(.W(COUNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (cnt_inc[g]),
      .cnt (cnt_val[g])
    );
  end

  assign match_cnt    = cnt_val[0];
  assign mismatch_cnt = cnt_val[1];
  assign fault_cnt    = cnt_val[2];

  // Checker-only state: has the memory ever reported ready since reset.
  logic seen_ready;
  always_ff @(posedge clk) begin
    if (rst) seen_ready <= 1'b0;
    else if (mem_ready) seen_ready <= 1'b1;
  end

  a_r1_wait_for_ready: assert property (@(posedge clk) disable iff (rst)
    wb_stb |-> seen_ready);
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_stall) |=>
      (wb_stb && $stable(wb_adr) && $stable(wb_we) && (!wb_we || $stable(wb_dat_w))));
  a_r9_fault_on_write: assert property (@(posedge clk) disable iff (rst)
    (fault_cnt != $past(fault_cnt)) |-> $past(wb_stb && !wb_stall && wb_we));
  a_r11_cyc_after_accept: assert property (@(posedge clk) disable iff (rst)
    $past(wb_stb && !wb_stall) |-> wb_cyc);
endmodule

// File: tb/tb_mem_traffic_exerciser.sv
module tb_mem_traffic_exerciser;
  localparam int AW    = 4;
  localparam int DW    = 32;
  localparam int BAW   = 8;
  localparam int DEPTH = 4;
  localparam int CW    = 8;
  localparam int N     = 1 << AW;
  localparam int H     = AW / 2;
  localparam int SEEDV = 9;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_ready = 1'b0, fault_inject = 1'b0;
  logic wb_stall = 1'b0, wb_ack = 1'b0;
  logic [DW-1:0] wb_dat_r = '0;
  logic wb_cyc, wb_stb, wb_we;
  logic [BAW-1:0] wb_adr;
  logic [DW-1:0] wb_dat_w;
  logic [DW/8-1:0] wb_sel;
  logic [CW-1:0] match_cnt, mismatch_cnt, fault_cnt;
  logic [1:0] mode;

  always #5 clk = ~clk;

  mem_traffic_exerciser #(
    .BUS_AW(BAW), .WORD_AW(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH),
    .COUNT_W(CW), .SEED(32'(SEEDV))
  ) dut (
    .clk(clk), .rst(rst), .mem_ready(mem_ready), .fault_inject(fault_inject),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_stall(wb_stall), .wb_ack(wb_ack),
    .wb_dat_r(wb_dat_r), .match_cnt(match_cnt), .mismatch_cnt(mismatch_cnt),
    .fault_cnt(fault_cnt), .mode(mode)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    logic [AW-1:0] k;
    logic [DW-1:0] r;
    k = AW'(a ^ SEEDV);
    for (int b = 0; b < DW; b++) r[b] = k[b % AW] ^ (((b / AW) % 2) == 1);
    return r;
  endfunction

  function automatic int swz(input int c);
    return ((c % (1 << H)) << (AW - H)) | (c >> H);
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // Expected request stream for one loop of the three patterns.
  int e_mode[$], e_we[$], e_adr[$];
  task automatic refill();
    for (int i = 0; i < N; i++) begin e_mode.push_back(0); e_we.push_back(1); e_adr.push_back(i); end
    for (int i = 0; i < N; i++) begin e_mode.push_back(0); e_we.push_back(0); e_adr.push_back(i); end
    for (int i = 0; i < N; i++) begin e_mode.push_back(1); e_we.push_back(1); e_adr.push_back(swz(i)); end
    for (int i = 0; i < N; i++) begin e_mode.push_back(1); e_we.push_back(0); e_adr.push_back(swz(i)); end
    for (int i = 0; i < N; i++) begin
      e_mode.push_back(2); e_we.push_back(1); e_adr.push_back(i);
      e_mode.push_back(2); e_we.push_back(0); e_adr.push_back(i);
    end
  endtask

  logic [DW-1:0] mem [N];
  int r_due[$], r_we[$], r_adr[$];
  logic [DW-1:0] r_dat[$];
  int m_match = 0, m_mis = 0, m_flt = 0, pulses = 0, max_out = 0, acc = 0;
  bit prev_hold = 0;
  logic [BAW-1:0] prev_adr;
  logic prev_we;
  logic [DW-1:0] prev_dat;

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(wb_stb == 0 && wb_cyc == 0, "R1", "request before ready", {wb_stb, wb_cyc}, 0);
      chk(match_cnt == 0 && mismatch_cnt == 0 && fault_cnt == 0, "R1", "counters after reset",
          match_cnt + mismatch_cnt + fault_cnt, 0);
      chk(mode == 0, "R1", "mode after reset", mode, 0);
    end
    mem_ready = 1'b1;

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      // Counters reflect every ack and accept up to the previous edge.
      chk(match_cnt == sat(m_match), "R8", "match_cnt", match_cnt, sat(m_match));
      chk(mismatch_cnt == sat(m_mis), "R8", "mismatch_cnt", mismatch_cnt, sat(m_mis));
      chk(fault_cnt == sat(m_flt), "R9", "fault_cnt", fault_cnt, sat(m_flt));
      chk(wb_cyc == (wb_stb || r_due.size() > 0), "R11", "wb_cyc", wb_cyc,
          (wb_stb || r_due.size() > 0));
      if (prev_hold)
        chk(wb_stb && wb_adr == prev_adr && wb_we == prev_we && (!wb_we || wb_dat_w == prev_dat),
            "R7", "held request changed", wb_adr, prev_adr);

      // Slave response: in order, with ack blackout windows to fill the queue.
      wb_ack = 1'b0;
      wb_dat_r = '0;
      if (!((n % 300) >= 150 && (n % 300) < 170) && r_due.size() > 0 && r_due[0] <= n) begin
        wb_ack = 1'b1;
        wb_dat_r = r_dat[0];
        if (r_we[0] == 0) begin
          if (r_dat[0] == pat(r_adr[0])) m_match++;
          else m_mis++;
        end
        void'(r_due.pop_front()); void'(r_we.pop_front());
        void'(r_adr.pop_front()); void'(r_dat.pop_front());
      end

      wb_stall = (n % 5 == 2) || ((n % 200) >= 100 && (n % 200) < 108) ||
                 (((n / 64) % 4) == 1 && (n % 2) == 0);

      if (wb_stb && !wb_stall) begin
        int em, ew, ea;
        string tg;
        if (e_mode.size() == 0) refill();
        em = e_mode.pop_front(); ew = e_we.pop_front(); ea = e_adr.pop_front();
        tg = (em == 0) ? "R3" : (em == 1) ? "R4" : "R5";
        chk(mode == 2'(em), "R2", "mode at request", mode, em);
        chk(int'(wb_adr) == ea, tg, "address", wb_adr, ea);
        chk(wb_we == 1'(ew), tg, "direction", wb_we, ew);
        chk(r_due.size() < DEPTH, "R8", "outstanding limit", r_due.size(), DEPTH - 1);
        if (wb_we) begin
          chk(wb_sel == '1, "R6", "byte enables", wb_sel, 4'hF);
          if (wb_dat_w == (pat(ea) ^ 32'd1)) m_flt++;
          else chk(wb_dat_w == pat(ea), "R6", "write data", wb_dat_w, pat(ea));
          mem[int'(wb_adr) % N] = wb_dat_w;
        end
        r_due.push_back(n + 1 + (acc % 3));
        r_we.push_back(int'(wb_we));
        r_adr.push_back(int'(wb_adr) % N);
        r_dat.push_back(wb_we ? '0 : mem[int'(wb_adr) % N]);
        acc++;
        if (r_due.size() > max_out) max_out = r_due.size();
      end
      prev_hold = wb_stb && wb_stall;
      prev_adr = wb_adr; prev_we = wb_we; prev_dat = wb_dat_w;

      fault_inject = (n == 300 || n == 512 || n == 731 || n == 953 || n == 1207);
      if (fault_inject) pulses++;
    end

    @(negedge clk);
    chk(m_flt == pulses, "R9", "corrupted writes per pulse", m_flt, pulses);
    chk(fault_cnt == 5, "R9", "final fault_cnt", fault_cnt, 5);
    chk(mismatch_cnt == fault_cnt, "R9", "mismatches equal faults", mismatch_cnt, fault_cnt);
    chk(m_match > CMAX && match_cnt == CMAX, "R10", "match_cnt saturated", match_cnt, CMAX);
    chk(max_out == DEPTH, "R8", "queue reached depth", max_out, DEPTH);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule